// File: doc/BRIEF.md
# Self-Timed Power-On Reset Generator

This block makes a synchronous, active-high reset for the rest of a design when no reset pin exists. It depends only on the values its registers take at power-up. After power-up it holds the reset high for a fixed number of clock cycles and then releases it. The reset is never reasserted unless a clock-manager lock signal is lost.

A lock indication from a clock manager can be chosen as the reset source. That lock input is first registered into the clock domain by a short flop chain. The registered signal clears a small counter, so every counter flop leaves its cleared state on the same edge. The counter counts up until its top bit sets, then it freezes. The frozen top bit is what releases the reset.

A second build option ignores the lock input. In that option the same register chain carries a constant high level, and that chain acts as the registered power-up condition.

Top module: `por_reset_gen`

## Requirements
- R1: Before the first rising clock edge, `rst_out` is 1. No reset input is used to get there.
- R2: With the lock input in use and `pll_locked` held at 1 from time zero, `rst_out` is 1 after every rising edge numbered below 2^(CNT_W-1)+SYNC_STAGES+1. It reads 0 after that edge. The first edge is numbered 1, and the defaults give edge 11.
- R3: Once `rst_out` has fallen, it stays 0 on every edge for as long as `pll_locked` stays 1. The counter never wraps back to zero by itself.
- R4: If `pll_locked` is 0 at rising edge e, then `rst_out` is 1 after edge e+SYNC_STAGES. A low level lasting a single cycle is enough, and it is not filtered out.
- R5: If `pll_locked` returns to 1 and is first seen high at edge f, then `rst_out` falls after edge f+SYNC_STAGES+2^(CNT_W-1) and not before. It stays 1 from the reassertion until that edge.
- R6: When LOCK_MODE is LOCK_IGNORED, `pll_locked` has no effect. `rst_out` falls after edge 2^(CNT_W-1)+SYNC_STAGES+1 and stays 0 from then on, whatever the lock input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; all state changes on its rising edge |
| pll_locked | input | 1 | Clock-manager lock level, asynchronous; 1 means the clock is stable |
| rst_out | output | 1 | Synchronous active-high reset for downstream logic |

## Verification
The assertions do not assume that `pll_locked` is synchronous. They also do not assume that it stays high for any minimum time, because the flop chain samples it on every edge. The assertions do assume that `clk` runs from power-up and that the registers start at their declared initial values. The bench keeps to these assumptions in two ways. It changes the lock input only on falling clock edges, so the edge at which each change is first seen is known exactly. It starts the clock at time zero with no reset of any kind.

// File: rtl/por_pkg.sv
package por_pkg;
   // Selects where the reset-release condition comes from
   typedef enum logic [0:0] {
      LOCK_SYNCED  = 1'b0,  // lock input is registered and gates the counter
      LOCK_IGNORED = 1'b1   // constant level through the chain; lock input unused
   } lock_mode_e;

   // Edge number (first edge = 1) after which reset reads low at power-up
   function automatic int unsigned release_edge(input int unsigned cnt_w,
                                                input int unsigned stages);
      return (32'd1 << (cnt_w - 1)) + stages + 1;
   endfunction
endpackage

// File: rtl/por_sync_chain.sv
module por_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic d_in,
   output logic d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("por_sync_chain: STAGES must be at least 2");
   end

   // Power-up value 0: the chain reads "not ready" until it has filled
   logic [STAGES-1:0] stg = '0;

   always_ff @(posedge clk) begin
      stg <= {stg[STAGES-2:0], d_in};
   end

   assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/por_hold_counter.sv
module por_hold_counter #(
   parameter int unsigned CNT_W = 4
) (
   input  logic clk,
   input  logic run_en,   // registered release condition; 0 clears the count
   output logic full
);
   localparam int unsigned MSB = CNT_W - 1;

   if (CNT_W < 2) begin : g_bad_width
      $error("por_hold_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt   = '0;
   logic             armed = 1'b0;

   always_ff @(posedge clk) begin
      armed <= 1'b1;
      if (!run_en)
         cnt <= '0;
      else if (!cnt[MSB])
         cnt <= cnt + 1'b1;
   end

   assign full = cnt[MSB];

   // R3
   cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!armed)
      $past(full) |-> (full || cnt == '0));

   // R4
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!armed)
      !run_en |=> (cnt == '0));
endmodule

// File: rtl/por_reset_gen.sv
module por_reset_gen #(
   parameter int unsigned          CNT_W       = 4,
   parameter int unsigned          SYNC_STAGES = 2,
   parameter por_pkg::lock_mode_e  LOCK_MODE   = por_pkg::LOCK_SYNCED
) (
   input  logic clk,
   input  logic pll_locked,
   output logic rst_out
);
   localparam int unsigned REL_EDGE = por_pkg::release_edge(CNT_W, SYNC_STAGES);

   if (REL_EDGE > 32'd1_000_000) begin : g_long_hold
      $error("por_reset_gen: hold time too long for a startup reset");
   end

   logic src_lvl;
   logic lock_s;
   logic cnt_full;
   logic rst_q = 1'b1;
   logic armed = 1'b0;

   if (LOCK_MODE == por_pkg::LOCK_SYNCED) begin : g_lock_src
      assign src_lvl = pll_locked;
   end else begin : g_const_src
      logic unused_lock;
      assign unused_lock = pll_locked;
      assign src_lvl     = 1'b1;
   end

   por_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .d_in   (src_lvl),
      .d_sync (lock_s)
   );

   por_hold_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .run_en (lock_s),
      .full   (cnt_full)
   );

   always_ff @(posedge clk) begin
      armed <= 1'b1;
      rst_q <= ~(cnt_full & lock_s);
   end

   assign rst_out = rst_q;

   // R2
   release_after_count_chk: assert property (@(posedge clk) disable iff (!armed)
      !rst_out |-> cnt_full);

   // R3
   stay_low_chk: assert property (@(posedge clk) disable iff (!armed)
      (!rst_out && lock_s) |=> !rst_out);

   // R4
   lock_drop_chk: assert property (@(posedge clk) disable iff (!armed)
      !lock_s |=> rst_out);
endmodule

// File: tb/tb_por_reset_gen.sv
module tb_por_reset_gen;
   localparam int unsigned W_A = 4, S_A = 2;
   localparam int unsigned W_B = 3, S_B = 3;
   localparam int REL_A = (1 << (W_A - 1)) + S_A + 1;   // 11
   localparam int REL_B = (1 << (W_B - 1)) + S_B + 1;   // 8

   logic clk = 1'b0;
   logic lock_a = 1'b1;
   logic lock_b = 1'b1;
   logic rst_a, rst_b;
   int   edge_n = 0;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   por_reset_gen #(.CNT_W(W_A), .SYNC_STAGES(S_A),
                   .LOCK_MODE(por_pkg::LOCK_SYNCED)) dut (
      .clk(clk), .pll_locked(lock_a), .rst_out(rst_a));

   por_reset_gen #(.CNT_W(W_B), .SYNC_STAGES(S_B),
                   .LOCK_MODE(por_pkg::LOCK_IGNORED)) dut_ign (
      .clk(clk), .pll_locked(lock_b), .rst_out(rst_b));

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s edge %0d: rst actual %b expected %b", req, edge_n, act, exp);
      end
   endtask

   // One rising edge, then sample at the falling edge; lock_b toggles each cycle
   task automatic tick(input string req_a, input logic exp_a);
      @(posedge clk);
      edge_n++;
      @(negedge clk);
      check(req_a, rst_a, exp_a);
      check("R6", rst_b, (edge_n < REL_B) ? 1'b1 : 1'b0);
      lock_b = ~lock_b;
   endtask

   // Lock low seen at edge e for len edges, then high from edge f = e+len
   task automatic drop_lock(input int len, input string req);
      int e;
      int f;
      e = edge_n + 1;
      f = e + len;
      lock_a = 1'b0;
      for (int k = 0; k < len; k++) begin
         tick(req, (edge_n + 1 >= e + S_A) ? 1'b1 : 1'b0);
      end
      lock_a = 1'b1;
      // R5: reset high until edge f+S+2^(W-1)
      for (int k = 0; k < S_A + (1 << (W_A - 1)) + 4; k++) begin
         tick(((edge_n + 1) >= e + S_A && (edge_n + 1) < f + S_A + (1 << (W_A - 1)))
                 ? "R5" : "R3",
              ((edge_n + 1) >= e + S_A && (edge_n + 1) < f + S_A + (1 << (W_A - 1)))
                 ? 1'b1 : 1'b0);
      end
   endtask

   initial begin
      #1;
      check("R1", rst_a, 1'b1);
      check("R1", rst_b, 1'b1);
      // R2: exact release edge with lock held from time zero
      for (int k = 1; k <= REL_A + 6; k++) begin
         tick("R2", (k < REL_A) ? 1'b1 : 1'b0);
      end
      // R3: stays low while locked
      for (int k = 0; k < 20; k++) tick("R3", 1'b0);
      // R4/R5: sweep lock-loss lengths, including a single-cycle dip
      for (int len = 1; len <= 6; len++) begin
         drop_lock(len, "R4");
         for (int k = 0; k < 3; k++) tick("R3", 1'b0);
      end
      drop_lock(12, "R4");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule